// File: doc/BRIEF.md
# Seven-Bit Serial Transceiver with Bit-Streamed Receive

This block is an asynchronous serial transmitter and receiver that share one bit clock rate. A frame on the line is a low start bit, seven data bits with the least significant bit first, an even parity bit over those seven bits, and a high stop bit. The line rests high between frames. The transmitter takes a seven-bit word on a single-cycle load pulse, sends the whole frame, and then shows that it can take the next word.

The receiver does not build a parallel word. It reports the start of each frame with a one-clock strobe and then hands out the eight bits that follow the start bit (the seven data bits, then the parity bit) one at a time on a single data output, each with its own one-clock valid strobe. A consumer that wants the bits one by one, such as a serial command decoder, can use them without a deserialiser. The number of clocks in one bit period is the system clock rate divided by the baud rate. Both rates are parameters. The transmit output can be wired straight back to the receive input.

Top module: `uart7_bitser`

## Requirements
- R1: After a synchronous reset, `line_out` is 1, `tx_ready` is 1, and `rx_frame_start` and `rx_bit_valid` are 0. A reset in the middle of a frame returns the line to 1 and `tx_ready` to 1.
- R2: When `tx_load` is 1 on a clock edge where `tx_ready` is 1, `line_out` becomes 0 after that edge. It then holds each of the ten frame bits for exactly BIT_CLKS = CLK_HZ/BAUD clocks, in this order: start (0), `tx_word[0]` to `tx_word[6]`, parity, stop (1).
- R3: `tx_ready` falls after the load edge and stays 0 for 10*BIT_CLKS clocks. It is 1 again on the clock after the stop bit ends.
- R4: A `tx_load` pulse while `tx_ready` is 0 has no effect. The frame in progress is unchanged and no second frame follows it.
- R5: The parity bit is even: the XOR of the seven data bits (0 when the count of ones is even).
- R6: `rx_frame_start` is a one-clock pulse, raised once per frame when `line_in` is still 0 half a bit period after its falling edge.
- R7: After each `rx_frame_start`, exactly eight `rx_bit_valid` pulses follow, each one clock wide and each at the centre of a bit. `rx_bit` carries data bit 0 first, then bits 1 to 6, then the parity bit as it was received, whether or not it matches the data. No bit pulse coincides with a frame-start pulse.
- R8: A low pulse on `line_in` that has ended by the half-bit check (for example 20 % or 40 % of a bit period) produces neither `rx_frame_start` nor `rx_bit_valid`.
- R9: With `line_out` looped back to `line_in`, every transmitted word is received with the same data bits and the same parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_word | input | 7 | Word to transmit |
| tx_load | input | 1 | One-cycle request to send `tx_word` |
| tx_ready | output | 1 | High when a new word can be loaded |
| line_out | output | 1 | Serial transmit line, idle high |
| line_in | input | 1 | Serial receive line, asynchronous |
| rx_bit | output | 1 | Current received bit |
| rx_bit_valid | output | 1 | One-cycle strobe marking `rx_bit` |
| rx_frame_start | output | 1 | One-cycle strobe on a confirmed start bit |

## Verification
The hardest case to reach is the short low pulse that must be rejected. The stimulus has to drop the receive line for only part of a bit period, and for less than the half-bit confirmation point once the two synchroniser stages are counted. The bench drives `line_in` directly with low pulses of two and four clocks against a ten-clock bit. It then watches the strobes for several bit periods. The parity pass-through case is also reached only by direct drive, by sending a frame whose parity bit deliberately does not match its data.

// File: rtl/uart7_pkg.sv
package uart7_pkg;

    localparam int unsigned WORD_W    = 7;
    localparam int unsigned FRAME_LEN = WORD_W + 3;
    localparam int unsigned RX_EMIT   = WORD_W + 1;

    typedef struct packed {
        logic              stop;
        logic              par;
        logic [WORD_W-1:0] data;
        logic              start;
    } frame_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP
    } rx_state_e;

    function automatic int unsigned bit_clocks(int unsigned clk_hz, int unsigned baud);
        return clk_hz / baud;
    endfunction

    function automatic logic even_par(logic [WORD_W-1:0] w);
        return ^w;
    endfunction

    function automatic frame_t make_frame(logic [WORD_W-1:0] w);
        frame_t f;
        f.start = 1'b0;
        f.data  = w;
        f.par   = even_par(w);
        f.stop  = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/uart7_sync.sv
module uart7_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1   <= RST_VAL;
            sync_out <= RST_VAL;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/uart7_tx.sv
module uart7_tx
    import uart7_pkg::*;
#(
    parameter int unsigned BIT_CLKS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word,
    input  logic              load,
    output logic              ready,
    output logic              line
);
    localparam int unsigned CNT_W = $clog2(BIT_CLKS);
    localparam int unsigned BC_W  = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIT_CLKS - 1);
    localparam logic [BC_W-1:0]  BIT_LAST = BC_W'(FRAME_LEN - 1);

    logic [FRAME_LEN-1:0] sreg;
    logic                 busy;
    logic [CNT_W-1:0]     clk_cnt;
    logic [BC_W-1:0]      bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg    <= '1;
            busy    <= 1'b0;
            clk_cnt <= '0;
            bit_cnt <= '0;
        end else if (!busy) begin
            if (load) begin
                sreg    <= make_frame(word);
                busy    <= 1'b1;
                clk_cnt <= '0;
                bit_cnt <= '0;
            end
        end else if (clk_cnt == CNT_LAST) begin
            clk_cnt <= '0;
            sreg    <= {1'b1, sreg[FRAME_LEN-1:1]};
            if (bit_cnt == BIT_LAST) begin
                busy <= 1'b0;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end else begin
            clk_cnt <= clk_cnt + 1'b1;
        end
    end

    assign ready = !busy;
    assign line  = sreg[0];
endmodule

// File: rtl/uart7_rx.sv
module uart7_rx
    import uart7_pkg::*;
#(
    parameter int unsigned BIT_CLKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic line_s,
    output logic bit_out,
    output logic bit_valid,
    output logic frame_start
);
    localparam int unsigned CNT_W = $clog2(BIT_CLKS);
    localparam int unsigned IDX_W = $clog2(RX_EMIT);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(BIT_CLKS - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(BIT_CLKS / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(RX_EMIT - 1);

    rx_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= RX_IDLE;
            cnt         <= '0;
            idx         <= '0;
            bit_out     <= 1'b1;
            bit_valid   <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            bit_valid   <= 1'b0;
            frame_start <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    cnt <= '0;
                    if (!line_s) state <= RX_START;
                end
                RX_START: begin
                    if (cnt == HALF_LAST) begin
                        cnt <= '0;
                        if (!line_s) begin
                            state       <= RX_BITS;
                            frame_start <= 1'b1;
                            idx         <= '0;
                        end else begin
                            state <= RX_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_BITS: begin
                    if (cnt == CNT_LAST) begin
                        cnt       <= '0;
                        bit_out   <= line_s;
                        bit_valid <= 1'b1;
                        if (idx == IDX_LAST) state <= RX_STOP;
                        else                 idx   <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == CNT_LAST) begin
                        cnt   <= '0;
                        state <= RX_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart7_bitser.sv
module uart7_bitser
    import uart7_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned BAUD   = 115_200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_load,
    output logic              tx_ready,
    output logic              line_out,
    input  logic              line_in,
    output logic              rx_bit,
    output logic              rx_bit_valid,
    output logic              rx_frame_start
);
    localparam int unsigned BIT_CLKS = bit_clocks(CLK_HZ, BAUD);

    logic line_s;

    uart7_tx #(.BIT_CLKS(BIT_CLKS)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .word  (tx_word),
        .load  (tx_load),
        .ready (tx_ready),
        .line  (line_out)
    );

    uart7_sync #(.RST_VAL(1'b1)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (line_in),
        .sync_out (line_s)
    );

    uart7_rx #(.BIT_CLKS(BIT_CLKS)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .line_s      (line_s),
        .bit_out     (rx_bit),
        .bit_valid   (rx_bit_valid),
        .frame_start (rx_frame_start)
    );
endmodule

// File: rtl/uart7_bitser_chk.sv
module uart7_bitser_chk (
    input logic       clk,
    input logic       rst,
    input logic [6:0] tx_word,
    input logic       tx_load,
    input logic       tx_ready,
    input logic       line_out,
    input logic       line_in,
    input logic       rx_bit,
    input logic       rx_bit_valid,
    input logic       rx_frame_start
);
    logic [3:0] bits_seen;

    always_ff @(posedge clk) begin
        if (rst)                 bits_seen <= '0;
        else if (rx_frame_start) bits_seen <= '0;
        else if (rx_bit_valid)   bits_seen <= bits_seen + 1'b1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_ready && line_out && !rx_bit_valid && !rx_frame_start));

    // R1
    idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> line_out);

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_load && tx_ready) |=> (!line_out && !tx_ready));

    // R6
    frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_frame_start |=> !rx_frame_start);

    // R7
    bit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_bit_valid |=> !rx_bit_valid);

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_bit_valid && rx_frame_start));

    // R7
    bit_count_chk: assert property (@(posedge clk) disable iff (rst)
        rx_bit_valid |-> (bits_seen < 4'd8));
endmodule

bind uart7_bitser uart7_bitser_chk u_chk (.*);

// File: tb/tb_uart7_bitser.sv
module tb_uart7_bitser;
    localparam int B = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] tx_word = '0;
    logic       tx_load = 1'b0;
    logic       tx_ready, line_out, line_in, rx_bit, rx_bit_valid, rx_frame_start;
    logic       drv = 1'b1;
    logic       loop_sel = 1'b1;

    int checks = 0;
    int errors = 0;
    int fs_cnt = 0;
    int vcnt = 0;
    int bidx = 0;
    logic [7:0] rxbits = '0;

    always #2 clk = ~clk;

    assign line_in = loop_sel ? line_out : drv;

    uart7_bitser #(.CLK_HZ(250_000_000), .BAUD(25_000_000)) dut (
        .clk(clk), .rst(rst), .tx_word(tx_word), .tx_load(tx_load),
        .tx_ready(tx_ready), .line_out(line_out), .line_in(line_in),
        .rx_bit(rx_bit), .rx_bit_valid(rx_bit_valid), .rx_frame_start(rx_frame_start)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_frame_start) begin
                fs_cnt++;
                bidx = 0;
            end
            if (rx_bit_valid) begin
                if (bidx < 8) rxbits[bidx] = rx_bit;
                bidx++;
                vcnt++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string msg,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, msg, act, exp);
        end
    endtask

    localparam logic [7:0] VEC [6] = '{
        {1'b0, 7'h00}, {1'b1, 7'h7F}, {1'b0, 7'h55},
        {1'b1, 7'h2A}, {1'b1, 7'h01}, {1'b1, 7'h40}
    };

    task automatic send_word(input logic [6:0] w, input logic p, input bit poke);
        logic [9:0] fr;
        int pos;
        int fs0;
        int bad;
        fr  = {1'b1, p, w, 1'b0};
        fs0 = fs_cnt;
        @(negedge clk); tx_word = w; tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
        pos = 1;
        check(tx_ready == 1'b0, "R3", "ready after load", 32'(tx_ready), 0);
        for (int j = 0; j < 10; j++) begin
            if (poke && j == 0) begin
                @(negedge clk); pos++; tx_word = ~w; tx_load = 1'b1;
                @(negedge clk); pos++; tx_load = 1'b0;
            end
            while (pos < j * B + B / 2) begin @(negedge clk); pos++; end
            check(line_out == fr[j], poke ? "R4" : (j == 8 ? "R5" : "R2"),
                  $sformatf("line bit %0d of word %0h", j, w), 32'(line_out), 32'(fr[j]));
        end
        while (pos < 10 * B) begin @(negedge clk); pos++; end
        check(tx_ready == 1'b0, "R3", "ready at last stop clock", 32'(tx_ready), 0);
        @(negedge clk);
        check(tx_ready == 1'b1, "R3", "ready after frame", 32'(tx_ready), 1);
        check(fs_cnt == fs0 + 1, "R6", "frame starts per frame", 32'(fs_cnt - fs0), 1);
        check(bidx == 8, "R7", "bits per frame", 32'(bidx), 8);
        check(rxbits == {p, w}, "R9", "loopback bits", 32'(rxbits), 32'({p, w}));
        if (poke) begin
            bad = 0;
            repeat (2 * B) begin
                @(negedge clk);
                if (line_out !== 1'b1 || tx_ready !== 1'b1) bad++;
            end
            check(bad == 0, "R4", "no second frame after ignored load", 32'(bad), 0);
        end
    endtask

    task automatic drive_frame(input logic [6:0] w, input logic p);
        logic [9:0] fr;
        int fs0;
        fr  = {1'b1, p, w, 1'b0};
        fs0 = fs_cnt;
        for (int j = 0; j < 10; j++) begin
            drv = fr[j];
            repeat (B) @(negedge clk);
        end
        drv = 1'b1;
        repeat (2 * B) @(negedge clk);
        check(fs_cnt == fs0 + 1, "R6", "direct frame start", 32'(fs_cnt - fs0), 1);
        check(bidx == 8, "R7", "direct bit count", 32'(bidx), 8);
        check(rxbits == {p, w}, "R7", "direct bits incl parity", 32'(rxbits), 32'({p, w}));
    endtask

    task automatic glitch(input int low_clks);
        int fs0;
        int v0;
        fs0 = fs_cnt;
        v0  = vcnt;
        drv = 1'b0;
        repeat (low_clks) @(negedge clk);
        drv = 1'b1;
        repeat (3 * B) @(negedge clk);
        check(fs_cnt == fs0, "R8", $sformatf("glitch %0d clk frame start", low_clks), 32'(fs_cnt - fs0), 0);
        check(vcnt == v0, "R8", $sformatf("glitch %0d clk bit strobes", low_clks), 32'(vcnt - v0), 0);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(tx_ready == 1'b1 && line_out == 1'b1, "R1", "state in reset",
              32'({tx_ready, line_out}), 32'h3);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(tx_ready == 1'b1 && line_out == 1'b1 && !rx_bit_valid && !rx_frame_start,
              "R1", "state after reset", 32'({tx_ready, line_out, rx_bit_valid, rx_frame_start}), 32'hC);

        for (int i = 0; i < 6; i++) begin
            send_word(VEC[i][6:0], VEC[i][7], 1'b0);
            repeat (B) @(negedge clk);
        end

        send_word(7'h33, 1'b0, 1'b1);

        loop_sel = 1'b0;
        repeat (B) @(negedge clk);
        drive_frame(7'h4B, 1'b0);
        drive_frame(7'h4B, 1'b1);
        drive_frame(7'h06, 1'b1);

        glitch(2);
        glitch(4);

        loop_sel = 1'b1;
        @(negedge clk); tx_word = 7'h12; tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
        repeat (3 * B) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(tx_ready == 1'b1 && line_out == 1'b1, "R1", "mid-frame reset",
              32'({tx_ready, line_out}), 32'h3);
        repeat (2 * B) @(negedge clk);

        send_word(7'h6C, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule